// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This unit sits beside a processor's bus and judges every access against up to eight address regions that software loads for the task now running. A region is a pair of inclusive bounds kept at 8-byte granularity plus four attribute bits: enable, write-forbidden, fetch-forbidden and peripheral-allowed. Each access arrives as an address, a kind (read, write or instruction fetch) and a privilege bit. Supervisor accesses are always allowed. User accesses must fall inside at least one enabled region. They must also respect the restrictions of every enabled region that covers them. When a user access targets the peripheral window, a covering region must carry the peripheral-allowed bit.

A refused access produces a one-cycle non-maskable interrupt pulse in the cycle after it is presented. The first refusal is kept in a sticky record of its address and kind. That record stays frozen until software clears it. The access input is a valid/ready stream. Ready is permanently high, so the unit never applies back-pressure and judges one access per cycle; a beat counts only while valid is high. Regions are loaded through a plain write port. A write takes effect from the following cycle.

Top module: `mpu_guard`

## Requirements
- R1: After reset every region is disabled, the interrupt output and the sticky flag are low, and the recorded address and kind are zero; a user access anywhere is then refused.
- R2: A region covers an access when lower bound <= address[22:3] <= upper bound (both inclusive); the low three address bits never affect matching.
- R3: A user write (kind 1) inside an enabled region whose attribute bit 1 (write-forbidden) is set is refused; reads and fetches there are allowed.
- R4: A user instruction fetch (kind 2) inside an enabled region whose attribute bit 2 (fetch-forbidden) is set is refused; reads there are allowed.
- R5: A user access covered by no enabled region (attribute bit 0 clear counts as not enabled) is refused; a user read (kind 0) inside an enabled region with no restriction bits is allowed.
- R6: An access with the supervisor input high is never refused.
- R7: A user access with address below PERIPH_TOP (default 0x000800) is refused unless a covering enabled region has attribute bit 3 (peripheral-allowed) set.
- R8: The interrupt output is high for exactly the cycle after a refused beat, and stays low after any cycle in which valid is low.
- R9: The first refusal sets the sticky flag and records its address and kind; while the flag is set, later refusals leave the record unchanged.
- R10: Pulsing the clear input drops the flag on the next edge; if a refusal occurs in the same cycle, that refusal is recorded and the flag stays set.
- R11: The ready output is high at all times, including reset.
- R12: Configuration writes pick the region by index and the field by code (0 lower bound, 1 upper bound, 2 attributes in data bits 3:0); field code 3 changes nothing, and a new setting governs accesses from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index |
| cfg_field | input | 2 | Field code: 0 lower, 1 upper, 2 attributes, 3 none |
| cfg_wdata | input | 20 | Bound in 8-byte units, or attributes in bits 3:0 |
| acc_valid | input | 1 | Access beat valid |
| acc_ready | output | 1 | Always high |
| acc_addr | input | 23 | Byte address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| acc_super | input | 1 | High for supervisor state |
| viol_clr | input | 1 | Clears the sticky record flag |
| nmi_pulse | output | 1 | One-cycle violation interrupt |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 23 | Address of the first recorded violation |
| viol_kind | output | 2 | Kind of the first recorded violation |

## Verification
The hardest case to reach from the ports is a clear and a new refusal landing on the same edge. At that moment the capture and the clear compete for the sticky record. The bench drives the clear strobe together with a refused user write. It then checks that the record holds the new address and kind and that the flag stays set. A second clear with no refusal must then drop the flag while the address is kept. Exact bound hits and near misses come from addresses one granule outside each region.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int ATTR_W   = 4;
  localparam int ATTR_EN  = 0;
  localparam int ATTR_NW  = 1;
  localparam int ATTR_NX  = 2;
  localparam int ATTR_POK = 3;

  localparam logic [1:0] FLD_LO   = 2'd0;
  localparam logic [1:0] FLD_HI   = 2'd1;
  localparam logic [1:0] FLD_ATTR = 2'd2;
  localparam logic [1:0] FLD_NONE = 2'd3;

endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_pkg::*;
#(
  parameter int N_REG = 8,
  parameter int BND_W = 20,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [1:0]                     cfg_field,
  input  logic [BND_W-1:0]               cfg_wdata,
  output logic [N_REG-1:0][BND_W-1:0]    lo_q,
  output logic [N_REG-1:0][BND_W-1:0]    hi_q,
  output logic [N_REG-1:0][ATTR_W-1:0]   attr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
    end else if (cfg_we && (int'(cfg_idx) < N_REG)) begin
      case (cfg_field)
        FLD_LO:   lo_q[cfg_idx]   <= cfg_wdata;
        FLD_HI:   hi_q[cfg_idx]   <= cfg_wdata;
        FLD_ATTR: attr_q[cfg_idx] <= cfg_wdata[ATTR_W-1:0];
        default:  ;
      endcase
    end
  end

  // field code 3 must leave the whole bank untouched
  assert_reserved_field_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == FLD_NONE) |=> ($stable(lo_q) && $stable(hi_q) && $stable(attr_q)));

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int BND_W = 20
) (
  input  logic [BND_W-1:0] granule,
  input  logic [BND_W-1:0] lo,
  input  logic [BND_W-1:0] hi,
  input  logic             en,
  output logic             hit
);

  always_comb begin
    hit = en && (granule >= lo) && (granule <= hi);
  end

endmodule

// File: rtl/mpu_viol_log.sv
module mpu_viol_log #(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        kind_i,
  input  logic              clr_i,
  output logic              nmi_o,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        kind_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_o  <= 1'b0;
      flag_o <= 1'b0;
      addr_o <= '0;
      kind_o <= '0;
    end else begin
      nmi_o <= fire;
      if (fire && (!flag_o || clr_i)) begin
        flag_o <= 1'b1;
        addr_o <= addr_i;
        kind_o <= kind_i;
      end else if (clr_i) begin
        flag_o <= 1'b0;
      end
    end
  end

  assert_record_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> (flag_o && $stable(addr_o) && $stable(kind_o)));

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire) |=> !flag_o);

  assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> flag_o);

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int                ADDR_W     = 23,
  parameter int                N_REGIONS  = 8,
  parameter int                GRAN_LOG2  = 3,
  parameter logic [ADDR_W-1:0] PERIPH_TOP = 23'h000800,
  localparam int               BND_W      = ADDR_W - GRAN_LOG2,
  localparam int               IDX_W      = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [BND_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  input  logic              viol_clr,
  output logic              nmi_pulse,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr,
  output logic [1:0]        viol_kind
);

  logic [N_REGIONS-1:0][BND_W-1:0]  lo_q;
  logic [N_REGIONS-1:0][BND_W-1:0]  hi_q;
  logic [N_REGIONS-1:0][ATTR_W-1:0] attr_q;
  logic [N_REGIONS-1:0]             hit_vec;
  logic [N_REGIONS-1:0]             nw_vec;
  logic [N_REGIONS-1:0]             nx_vec;
  logic [N_REGIONS-1:0]             pok_vec;
  logic                             in_periph;
  logic                             violate;
  logic                             fire;

  assign acc_ready = 1'b1;

  mpu_region_bank #(.N_REG(N_REGIONS), .BND_W(BND_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .attr_q    (attr_q)
  );

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
    mpu_region_match #(.BND_W(BND_W)) u_match (
      .granule (acc_addr[ADDR_W-1:GRAN_LOG2]),
      .lo      (lo_q[g]),
      .hi      (hi_q[g]),
      .en      (attr_q[g][ATTR_EN]),
      .hit     (hit_vec[g])
    );
    assign nw_vec[g]  = attr_q[g][ATTR_NW];
    assign nx_vec[g]  = attr_q[g][ATTR_NX];
    assign pok_vec[g] = attr_q[g][ATTR_POK];
  end

  assign in_periph = (acc_addr < PERIPH_TOP);

  always_comb begin
    violate = 1'b0;
    if (!acc_super) begin
      if (hit_vec == '0) begin
        violate = 1'b1;
      end else begin
        if ((acc_kind == ACC_WRITE) && |(hit_vec & nw_vec)) violate = 1'b1;
        if ((acc_kind == ACC_FETCH) && |(hit_vec & nx_vec)) violate = 1'b1;
        if (in_periph && !(|(hit_vec & pok_vec)))            violate = 1'b1;
      end
    end
  end

  assign fire = acc_valid && acc_ready && violate;

  mpu_viol_log #(.ADDR_W(ADDR_W)) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .addr_i (acc_addr),
    .kind_i (acc_kind),
    .clr_i  (viol_clr),
    .nmi_o  (nmi_pulse),
    .flag_o (viol_flag),
    .addr_o (viol_addr),
    .kind_o (viol_kind)
  );

  assert_no_region_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_super && hit_vec == '0) |=> nmi_pulse);

  assert_write_forbidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_super && acc_kind == ACC_WRITE && |(hit_vec & nw_vec)) |=> nmi_pulse);

  assert_fetch_forbidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_super && acc_kind == ACC_FETCH && |(hit_vec & nx_vec)) |=> nmi_pulse);

  assert_supervisor_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_super) |=> !nmi_pulse);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !nmi_pulse);

endmodule

// File: tb/tb_mpu_guard.sv
module tb_mpu_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // {super, kind[1:0], addr[22:0], expect_pulse}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 2'd0, 23'h001000, 1'b0},  // R2 lower bound exact
    {1'b0, 2'd0, 23'h001FFF, 1'b0},  // R2 upper bound, low bits ignored
    {1'b0, 2'd0, 23'h000FFF, 1'b1},  // R2 one byte below -> first violation
    {1'b0, 2'd0, 23'h0020FF, 1'b0},  // R5 read in covered area
    {1'b0, 2'd0, 23'h002100, 1'b1},  // R2 one granule past end
    {1'b0, 2'd1, 23'h002010, 1'b1},  // R3 write forbidden
    {1'b0, 2'd1, 23'h001010, 1'b0},  // R3 write allowed elsewhere
    {1'b0, 2'd2, 23'h003008, 1'b1},  // R4 fetch forbidden
    {1'b0, 2'd2, 23'h001008, 1'b0},  // R4 fetch allowed elsewhere
    {1'b0, 2'd0, 23'h003008, 1'b0},  // R4 read in no-fetch region
    {1'b0, 2'd0, 23'h000410, 1'b0},  // R7 peripheral allowed
    {1'b0, 2'd1, 23'h000610, 1'b1},  // R7 peripheral not allowed
    {1'b0, 2'd0, 23'h005000, 1'b1},  // R5 disabled region
    {1'b1, 2'd1, 23'h002010, 1'b0},  // R6 supervisor write
    {1'b1, 2'd2, 23'h000000, 1'b0}   // R6 supervisor fetch in peripheral space
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_field = '0;
  logic [19:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [22:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_super = 1'b0;
  logic        viol_clr = 1'b0;
  logic        nmi_pulse;
  logic        viol_flag;
  logic [22:0] viol_addr;
  logic [1:0]  viol_kind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_guard dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_addr  (acc_addr),
    .acc_kind  (acc_kind),
    .acc_super (acc_super),
    .viol_clr  (viol_clr),
    .nmi_pulse (nmi_pulse),
    .viol_flag (viol_flag),
    .viol_addr (viol_addr),
    .viol_kind (viol_kind)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [1:0] fld, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one beat, returns the pulse seen one edge later
  task automatic access(input logic sup, input logic [1:0] kind, input logic [22:0] addr,
                        input logic clr, output logic pulse);
    @(negedge clk);
    acc_valid = 1'b1; acc_super = sup; acc_kind = kind; acc_addr = addr; viol_clr = clr;
    @(negedge clk);
    pulse = nmi_pulse;
    acc_valid = 1'b0; viol_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 ready
    chk(nmi_pulse == 1'b0, "R1 pulse after reset", nmi_pulse, 0);
    chk(viol_flag == 1'b0, "R1 flag after reset", viol_flag, 0);
    chk(viol_addr == '0, "R1 record address after reset", viol_addr, 0);
    chk(acc_ready == 1'b1, "R11 ready high", acc_ready, 1);
    access(1'b0, 2'd0, 23'h001000, 1'b0, p);
    chk(p == 1'b1, "R1 all regions disabled", p, 1);
    clear_flag();
    chk(viol_flag == 1'b0, "R10 clear alone", viol_flag, 0);

    // region setup (bounds in 8-byte units)
    cfg_write(3'd0, 2'd0, 20'h00200); cfg_write(3'd0, 2'd1, 20'h003FF); cfg_write(3'd0, 2'd2, 20'h1);
    cfg_write(3'd1, 2'd0, 20'h00400); cfg_write(3'd1, 2'd1, 20'h0041F); cfg_write(3'd1, 2'd2, 20'h3);
    cfg_write(3'd2, 2'd0, 20'h00600); cfg_write(3'd2, 2'd1, 20'h0061F); cfg_write(3'd2, 2'd2, 20'h5);
    cfg_write(3'd3, 2'd0, 20'h00080); cfg_write(3'd3, 2'd1, 20'h0009F); cfg_write(3'd3, 2'd2, 20'h9);
    cfg_write(3'd4, 2'd0, 20'h000C0); cfg_write(3'd4, 2'd1, 20'h000DF); cfg_write(3'd4, 2'd2, 20'h1);
    cfg_write(3'd5, 2'd0, 20'h00A00); cfg_write(3'd5, 2'd1, 20'h00A1F); cfg_write(3'd5, 2'd2, 20'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][26], VEC[i][25:24], VEC[i][23:1], 1'b0, p);
      chk(p == VEC[i][0], $sformatf("table vector %0d (R2 R3 R4 R5 R6 R7)", i), p, VEC[i][0]);
    end
    // R9 first violation kept across the table
    chk(viol_flag == 1'b1, "R9 flag set", viol_flag, 1);
    chk(viol_addr == 23'h000FFF, "R9 first address kept", viol_addr, 23'h000FFF);
    chk(viol_kind == 2'd0, "R9 first kind kept", viol_kind, 0);

    // R8 single-cycle pulse and idle beats
    access(1'b0, 2'd1, 23'h002010, 1'b0, p);
    chk(p == 1'b1, "R8 pulse after refused beat", p, 1);
    @(negedge clk);
    chk(nmi_pulse == 1'b0, "R8 pulse lasts one cycle", nmi_pulse, 0);
    acc_super = 1'b0; acc_kind = 2'd1; acc_addr = 23'h002010;
    @(negedge clk);
    @(negedge clk);
    chk(nmi_pulse == 1'b0, "R8 no pulse while valid low", nmi_pulse, 0);

    // R10 clear and refusal on the same edge
    access(1'b0, 2'd1, 23'h000610, 1'b1, p);
    chk(p == 1'b1, "R10 pulse with clear", p, 1);
    chk(viol_flag == 1'b1, "R10 flag stays set", viol_flag, 1);
    chk(viol_addr == 23'h000610, "R10 new address recorded", viol_addr, 23'h000610);
    chk(viol_kind == 2'd1, "R10 new kind recorded", viol_kind, 1);
    clear_flag();
    chk(viol_flag == 1'b0, "R10 flag cleared", viol_flag, 0);
    chk(viol_addr == 23'h000610, "R10 address kept after clear", viol_addr, 23'h000610);

    // R9 capture then freeze
    access(1'b0, 2'd2, 23'h003008, 1'b0, p);
    access(1'b0, 2'd1, 23'h002010, 1'b0, p);
    chk(viol_addr == 23'h003008, "R9 later refusal ignored (addr)", viol_addr, 23'h003008);
    chk(viol_kind == 2'd2, "R9 later refusal ignored (kind)", viol_kind, 2);

    // R12 reserved field, reprogramming
    cfg_write(3'd0, 2'd3, 20'h00000);
    access(1'b0, 2'd0, 23'h001000, 1'b0, p);
    chk(p == 1'b0, "R12 field 3 changes nothing", p, 0);
    cfg_write(3'd1, 2'd2, 20'h1);
    access(1'b0, 2'd1, 23'h002010, 1'b0, p);
    chk(p == 1'b0, "R12 write-forbidden removed", p, 0);
    cfg_write(3'd0, 2'd1, 20'h00200);
    access(1'b0, 2'd0, 23'h001007, 1'b0, p);
    chk(p == 1'b0, "R12 R2 single-granule region hit", p, 0);
    access(1'b0, 2'd0, 23'h001008, 1'b0, p);
    chk(p == 1'b1, "R12 R2 narrowed upper bound", p, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule